// File: doc/BRIEF.md
# Registered Pad Interface Cell

This block sits between the logic array and a row of pad drivers. Each lane carries one outgoing signal and one incoming signal. Both directions have a D flip-flop clocked by a dedicated I/O clock. Each flip-flop loads only while its own data enable is high, and a per-lane configuration bit can bypass it so that the path becomes purely combinational.

All registers share one asynchronous preset/clear line. For each lane, a configuration bit decides whether that line forces the lane's registers to one or to zero. The line acts at once and overrides the clock, the enables and the synchronous reset.

A return output hands a signal back to the array. It carries either the incoming path (registered or bypassed) or the outgoing register's Q. When it carries the outgoing Q, that register can serve as a state bit in fast state machines.

Top module: `reg_io_cell`

## Requirements
- R1: On a rising io_clk edge with out_en[i]=1, the outgoing register of lane i takes core_out[i]; with cfg_out_bypass[i]=0, pad_out[i] shows that register.
- R2: On a rising io_clk edge with out_en[i]=0, the outgoing register of lane i keeps its value.
- R3: With cfg_out_bypass[i]=1, pad_out[i] follows core_out[i] combinationally, within the same cycle.
- R4: The incoming register of lane i loads pad_in[i] on a rising edge only when in_en[i]=1, and otherwise holds. With cfg_in_bypass[i]=0 and cfg_y_from_out[i]=0, core_y[i] shows this register.
- R5: With cfg_in_bypass[i]=1 and cfg_y_from_out[i]=0, core_y[i] follows pad_in[i] combinationally.
- R6: While pcl=1, both registers of lane i take the value cfg_preset[i] (1 = preset, 0 = clear) without waiting for a clock edge. They keep that value across clock edges whatever the enables and data are.
- R7: With cfg_y_from_out[i]=1, core_y[i] equals the outgoing register's Q, also when the outgoing path is bypassed.
- R8: A rising edge with rst_n=0 clears both registers of every lane, unless pcl=1, which takes priority.
- R9: Lanes are independent: the configuration, enables and data of one lane never affect another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | Dedicated I/O clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcl | input | 1 | Shared asynchronous preset/clear, active high |
| cfg_out_bypass | input | LANES | Per-lane bypass of the outgoing register |
| cfg_in_bypass | input | LANES | Per-lane bypass of the incoming register |
| cfg_preset | input | LANES | Per-lane pcl action: 1 = preset, 0 = clear |
| cfg_y_from_out | input | LANES | Per-lane return select: 1 = outgoing Q, 0 = incoming path |
| core_out | input | LANES | Data from the array toward the pads |
| out_en | input | LANES | Outgoing register data enable |
| pad_out | output | LANES | Data to the pad drivers |
| pad_in | input | LANES | Data from the pad drivers |
| in_en | input | LANES | Incoming register data enable |
| core_y | output | LANES | Return signal to the array |

## Verification
The bench toggles the enables at random. A register that loads while its enable is low, or that drops a load, shows up as a pad_out or core_y mismatch one cycle later. Bypass is checked within the same cycle, right after new inputs are applied, so a path that stays registered lags one cycle and fails.

pcl is raised between clock edges and checked before the next edge. This exposes a synchronous implementation, a preset/clear polarity swapped in one lane, or enables that override pcl. Return selection is tested with the outgoing path bypassed, so a return mux wired to pad_out instead of Q gives the combinational value and not the stored one.

// File: rtl/iocell_pkg.sv
// Shared constants for the registered pad interface cell.
// Assumes nothing beyond being compiled before the modules that import it.
package iocell_pkg;
    localparam int unsigned IOC_LANES_DEF = 4;
    typedef enum logic {PCL_CLEARS = 1'b0, PCL_PRESETS = 1'b1} pcl_kind_e;
endpackage

// File: rtl/iocell_store.sv
// Bank of enabled D flip-flops with a shared asynchronous preset/clear.
// pcl (active high) forces bit i to pcl_kind[i] at once; it beats the
// synchronous active-low reset, which beats the per-bit enable.
// Assumes pcl_kind is static configuration.
module iocell_store #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pcl,
    input  logic [W-1:0] pcl_kind,
    input  logic [W-1:0] en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import iocell_pkg::*;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            // One flip-flop per lane: async force, then reset, then enabled load.
            always_ff @(posedge clk or posedge pcl) begin
                if (pcl)
                    q[gi] <= (pcl_kind_e'(pcl_kind[gi]) == PCL_PRESETS);
                else if (!rst_n)
                    q[gi] <= 1'b0;
                else if (en[gi])
                    q[gi] <= d[gi];
            end
        end
    endgenerate

    // Checker qualifier: high once a clean edge (no reset, no pcl) has passed.
    logic clean_q;
    always_ff @(posedge clk or posedge pcl) begin
        if (pcl)
            clean_q <= 1'b0;
        else
            clean_q <= rst_n;
    end

    // Disabled bits keep their value across a clean edge.
    p_hold_r2_r4: assert property (@(posedge clk) disable iff (!rst_n || pcl)
        clean_q |-> (((q ^ $past(q)) & ~$past(en)) == '0));

    // Enabled bits take the data present at the edge.
    p_load_r1_r4: assert property (@(posedge clk) disable iff (!rst_n || pcl)
        clean_q |-> ((($past(d) ^ q) & $past(en)) == '0));

    // While pcl is held, every bit sits at its configured level.
    p_async_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pcl |-> (q == pcl_kind));
endmodule

// File: rtl/iocell_pathsel.sv
// Per-lane two-way selector: bit i takes alt[i] when pick_alt[i] is high,
// otherwise base[i]. Used for both bypass and return selection.
// Assumes selects are static or change only between clock edges.
module iocell_pathsel #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] pick_alt,
    input  logic [W-1:0] base,
    input  logic [W-1:0] alt,
    output logic [W-1:0] y
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_lane
            // Purely combinational choice for one lane.
            always_comb y[gi] = pick_alt[gi] ? alt[gi] : base[gi];
        end
    endgenerate
endmodule

// File: rtl/reg_io_cell.sv
// Registered pad interface cell, LANES lanes wide. Each lane has an outgoing
// and an incoming register on io_clk, with their own enables and bypasses.
// A shared async pcl presets or clears them per lane, and a return output
// gives the array either the incoming path or the outgoing register's Q.
// Assumes cfg_* are static while the cell is in use.
module reg_io_cell #(
    parameter int unsigned LANES = iocell_pkg::IOC_LANES_DEF
) (
    input  logic             io_clk,
    input  logic             rst_n,
    input  logic             pcl,
    input  logic [LANES-1:0] cfg_out_bypass,
    input  logic [LANES-1:0] cfg_in_bypass,
    input  logic [LANES-1:0] cfg_preset,
    input  logic [LANES-1:0] cfg_y_from_out,
    input  logic [LANES-1:0] core_out,
    input  logic [LANES-1:0] out_en,
    output logic [LANES-1:0] pad_out,
    input  logic [LANES-1:0] pad_in,
    input  logic [LANES-1:0] in_en,
    output logic [LANES-1:0] core_y
);
    logic [LANES-1:0] q_out;
    logic [LANES-1:0] q_in;
    logic [LANES-1:0] in_path;

    iocell_store #(.W(LANES)) i_out_reg (
        .clk(io_clk), .rst_n(rst_n), .pcl(pcl), .pcl_kind(cfg_preset),
        .en(out_en), .d(core_out), .q(q_out)
    );

    iocell_store #(.W(LANES)) i_in_reg (
        .clk(io_clk), .rst_n(rst_n), .pcl(pcl), .pcl_kind(cfg_preset),
        .en(in_en), .d(pad_in), .q(q_in)
    );

    iocell_pathsel #(.W(LANES)) i_out_sel (
        .pick_alt(cfg_out_bypass), .base(q_out), .alt(core_out), .y(pad_out)
    );

    iocell_pathsel #(.W(LANES)) i_in_sel (
        .pick_alt(cfg_in_bypass), .base(q_in), .alt(pad_in), .y(in_path)
    );

    iocell_pathsel #(.W(LANES)) i_y_sel (
        .pick_alt(cfg_y_from_out), .base(in_path), .alt(q_out), .y(core_y)
    );

    // With feedback selected and the outgoing path registered, the return
    // and the pad output must agree.
    p_yfeed_r7: assert property (@(posedge io_clk) disable iff (!rst_n)
        ((cfg_y_from_out & ~cfg_out_bypass & (core_y ^ pad_out)) == '0));
endmodule

// File: tb/test_reg_io_cell.sv
module test_reg_io_cell;
    localparam int N = 4;

    logic io_clk = 1'b0;
    logic rst_n, pcl;
    logic [N-1:0] cfg_out_bypass, cfg_in_bypass, cfg_preset, cfg_y_from_out;
    logic [N-1:0] core_out, out_en, pad_in, in_en;
    logic [N-1:0] pad_out, core_y;

    int checks = 0;
    int errors = 0;
    bit mo[N];
    bit mi[N];

    always #5 io_clk = ~io_clk;

    reg_io_cell #(.LANES(N)) i_reg_io_cell (
        .io_clk(io_clk), .rst_n(rst_n), .pcl(pcl),
        .cfg_out_bypass(cfg_out_bypass), .cfg_in_bypass(cfg_in_bypass),
        .cfg_preset(cfg_preset), .cfg_y_from_out(cfg_y_from_out),
        .core_out(core_out), .out_en(out_en), .pad_out(pad_out),
        .pad_in(pad_in), .in_en(in_en), .core_y(core_y)
    );

    // Reference: async force on pcl.
    task automatic model_force();
        for (int i = 0; i < N; i++) begin
            mo[i] = cfg_preset[i];
            mi[i] = cfg_preset[i];
        end
    endtask

    // Reference: one rising edge.
    task automatic model_edge();
        for (int i = 0; i < N; i++) begin
            if (pcl) begin
                mo[i] = cfg_preset[i];
                mi[i] = cfg_preset[i];
            end else if (!rst_n) begin
                mo[i] = 0;
                mi[i] = 0;
            end else begin
                if (out_en[i]) mo[i] = core_out[i];
                if (in_en[i]) mi[i] = pad_in[i];
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [N-1:0] ep, ey;
        for (int i = 0; i < N; i++) begin
            ep[i] = cfg_out_bypass[i] ? core_out[i] : mo[i];
            ey[i] = cfg_y_from_out[i] ? mo[i] : (cfg_in_bypass[i] ? pad_in[i] : mi[i]);
        end
        checks++;
        if (pad_out !== ep) begin
            errors++;
            $display("FAIL %s pad_out actual %b expected %b t=%0t", tag, pad_out, ep, $time);
        end
        checks++;
        if (core_y !== ey) begin
            errors++;
            $display("FAIL %s core_y actual %b expected %b t=%0t", tag, core_y, ey, $time);
        end
    endtask

    // One cycle: drive at negedge, check combinational, clock, check registered.
    task automatic cycle(input string tag, input logic [N-1:0] co, oe, pi, ie);
        core_out = co; out_en = oe; pad_in = pi; in_en = ie;
        #1 compare(tag);
        @(posedge io_clk);
        model_edge();
        @(negedge io_clk);
        compare(tag);
    endtask

    task automatic rand_cycles(input string tag, input int n);
        for (int k = 0; k < n; k++)
            cycle(tag, N'($urandom), N'($urandom), N'($urandom), N'($urandom));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; pcl = 0;
        cfg_out_bypass = '0; cfg_in_bypass = '0; cfg_preset = '0; cfg_y_from_out = '0;
        core_out = '1; out_en = '1; pad_in = '1; in_en = '1;
        @(posedge io_clk);
        model_edge();
        @(negedge io_clk);
        // R8: reset clears both registers even with enables high
        compare("R8 reset");
        cfg_y_from_out = '1;
        #1 compare("R8 reset out reg");
        cfg_y_from_out = '0;
        rst_n = 1;

        // R1 R2 R4: registered paths with random enables
        rand_cycles("R1/R2/R4 registered", 40);
        cycle("R2 hold all", '1, '0, '1, '0);
        cycle("R2 hold all", '0, '0, '0, '0);

        // R3 R5: both bypassed
        cfg_out_bypass = '1; cfg_in_bypass = '1;
        rand_cycles("R3/R5 bypass", 20);

        // R7: return from outgoing Q while the outgoing path is bypassed
        cfg_y_from_out = '1;
        rand_cycles("R7 feedback", 20);
        cfg_out_bypass = '0;
        rand_cycles("R7 feedback registered", 10);

        // R6: async preset/clear, mixed polarity
        cfg_y_from_out = '0; cfg_in_bypass = '0;
        for (int m = 0; m < 2; m++) begin
            cfg_preset = (m == 0) ? 4'b0101 : 4'b1010;
            core_out = ~cfg_preset; pad_in = ~cfg_preset;
            #1 pcl = 1;
            model_force();
            #1 compare("R6 async immediate");
            cfg_y_from_out = '1;
            #1 compare("R6 async immediate out reg");
            cfg_y_from_out = '0;
            @(negedge io_clk);
            for (int k = 0; k < 3; k++)
                cycle("R6 held over enables", N'($urandom), '1, N'($urandom), '1);
            rst_n = 0;
            cycle("R8 pcl beats reset", '1, '1, '1, '1);
            rst_n = 1;
            pcl = 0;
            rand_cycles("R6 release", 4);
        end

        // R9: random independent per-lane configuration
        for (int c = 0; c < 8; c++) begin
            cfg_out_bypass = N'($urandom); cfg_in_bypass = N'($urandom);
            cfg_preset = N'($urandom); cfg_y_from_out = N'($urandom);
            rand_cycles("R9 mixed lanes", 8);
            pcl = 1;
            model_force();
            #1 compare("R9 mixed lanes pcl");
            @(negedge io_clk);
            pcl = 0;
            rand_cycles("R9 mixed lanes", 4);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule